// File: doc/BRIEF.md
# Multiple single-input-change pattern generator

This block builds scan stimulus in which each scan chain receives a low-transition bit stream instead of raw pseudorandom data. A slowly stepping seed register (a maximal-length Galois LFSR) is combined bit by bit with a fast Johnson counter. The Johnson word is rotated one place per shift tick, so over one pattern of `CHAIN_LEN` shift ticks each chain is filled with a different rotation of the same Johnson word, inverted wherever its seed bit is set. The full seed word is driven onto the primary-input pins for the whole time the chains are loading.

A sequencer runs three nested loops. For every seed it walks the Johnson counter through all of its `2*CHAIN_LEN` states. For each state it shifts `CHAIN_LEN` codeword bits into every chain and then spends one capture cycle with scan enable low. After the last Johnson state the seed steps once. The run ends after `test_length` seeds and raises `done`, which holds until the next `start`. The fast test clock is modelled as the enable `tick`. The slow seed clock is an internal strobe that fires once per seed.

Top module: `msic_pattern_gen`

## Requirements
- R1: After reset, `scan_enable` and `done` are 0, `pi_out` equals `SEED_INIT` (default 8'h01) and `scan_in` equals the low `NUM_CHAINS` seed bits (4'b0001 by default).
- R2: While idle or done, a `seed_load` pulse with a nonzero `seed_value` loads that value into the seed on the next cycle. A zero `seed_value` is ignored, so the seed is never zero.
- R3: `seed_load` has no effect while a run is active (from the `start` edge until `done`).
- R4: Johnson state v (v = 0..2L-1, L = `CHAIN_LEN`) has bit b set when b < v for v <= L, and when b >= v-L for v > L. On shift tick k (0..L-1) of the pattern for state v, chain i receives `J_v[(i-k) mod L] XOR seed[i]`. Patterns run through v = 0..2L-1 in order for each seed.
- R5: After all 2L Johnson states of a seed, the seed steps once by the Galois right shift `next = (s >> 1) XOR (s[0] ? 8'hB8 : 0)`.
- R6: `scan_enable` is high for each pattern's L shift ticks. Between consecutive patterns it is low for exactly one clock cycle (the capture cycle).
- R7: A shift cycle with `tick` low moves nothing: the same codeword bit is offered again on the next tick.
- R8: A run of nonzero `test_length` N delivers exactly N*2L*L shift ticks and then raises `done`. A `test_length` of zero raises `done` with no shift cycle.
- R9: `start` clears `done` and begins shifting in the next cycle. `done` holds until the next `start`.
- R10: `pi_out` equals the current seed during every shift cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Fast test-clock enable; one shift per high cycle |
| start | input | 1 | Begins a run when idle or done |
| seed_load | input | 1 | Loads `seed_value` into the seed when idle or done |
| seed_value | input | NUM_PI | Seed to load (zero is rejected) |
| test_length | input | LEN_W | Number of seeds a run consumes |
| scan_in | output | NUM_CHAINS | Serial data for each scan chain |
| pi_out | output | NUM_PI | Seed word driven to the primary inputs |
| scan_enable | output | 1 | High while shifting, low in capture and idle |
| done | output | 1 | Run finished |

## Verification
The assertions assume that `tick` is a plain per-cycle enable and that `start` and `seed_load` are honoured only when the sequencer is idle or done. Under those assumptions the single-bit change per Johnson step, the stability of the seed and the single capture cycle must hold. The stimulus raises `start` only after `done`, or once from idle after reset. It moves `seed_load` in the middle of a run only in the one case that checks it is ignored. It keeps `test_length` small, so every run finishes quickly and every shifted bit is compared against the predicted stream.

// File: rtl/msic_pkg.sv
package msic_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SHIFT   = 2'd1,
      ST_CAPTURE = 2'd2,
      ST_DONE    = 2'd3
   } seq_state_t;
endpackage

// File: rtl/msic_seed_lfsr.sv
module msic_seed_lfsr #(
   parameter int              WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS = 8'hB8,
   parameter logic [WIDTH-1:0] INIT = 8'h01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_val,
   input  logic             step_en,
   output logic [WIDTH-1:0] seed
);
   if (WIDTH < 2) begin : g_bad_width
      $error("seed width must be at least 2");
   end
   if (INIT == '0) begin : g_bad_init
      $error("seed reset value must be nonzero");
   end

   logic [WIDTH-1:0] stepped;
   assign stepped = {1'b0, seed[WIDTH-1:1]} ^ (seed[0] ? TAPS : '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                        seed <= INIT;
      else if (load_en && load_val != '0) seed <= load_val;
      else if (step_en)                  seed <= stepped;
   end

   // R2: seed register never holds the all-zero lock-up state
   a_r2_seed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      seed != '0);
   // R3: without a load or a step the seed does not move
   a_r3_seed_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !step_en) |=> $stable(seed));
endmodule

// File: rtl/msic_johnson.sv
module msic_johnson #(
   parameter int LEN = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           rotate,
   input  logic           advance,
   output logic [LEN-1:0] word
);
   if (LEN < 2) begin : g_bad_len
      $error("Johnson length must be at least 2");
   end

   logic [LEN-1:0] jcnt;
   logic [LEN-1:0] jnext;
   assign jnext = {jcnt[LEN-2:0], ~jcnt[LEN-1]};

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         jcnt <= '0;
         word <= '0;
      end else if (advance) begin
         jcnt <= jnext;
         word <= jnext;
      end else if (rotate) begin
         word <= {word[LEN-2:0], word[LEN-1]};
      end
   end

   // R4: every Johnson step flips exactly one bit (single input change)
   a_r4_one_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> ($countones(jcnt ^ $past(jcnt)) == 1));
endmodule

// File: rtl/msic_sequencer.sv
module msic_sequencer
   import msic_pkg::*;
#(
   parameter int CHAIN_LEN = 4,
   parameter int LEN_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic [LEN_W-1:0] test_length,
   output logic             quiet,
   output logic             clear_j,
   output logic             rotate,
   output logic             advance_j,
   output logic             step_seed,
   output logic             scan_enable,
   output logic             done
);
   localparam int SH_W  = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
   localparam int VEC_N = 2 * CHAIN_LEN;
   localparam int VEC_W = $clog2(VEC_N);

   seq_state_t       state;
   logic [SH_W-1:0]  shift_cnt;
   logic [VEC_W-1:0] vec_cnt;
   logic [LEN_W-1:0] seed_cnt;
   logic             last_shift, last_vec, last_seed;

   assign last_shift  = shift_cnt == SH_W'(CHAIN_LEN - 1);
   assign last_vec    = vec_cnt == VEC_W'(VEC_N - 1);
   assign last_seed   = (seed_cnt + LEN_W'(1)) == test_length;
   assign quiet       = (state == ST_IDLE) || (state == ST_DONE);
   assign clear_j     = quiet && start;
   assign rotate      = (state == ST_SHIFT) && tick;
   assign advance_j   = state == ST_CAPTURE;
   assign step_seed   = (state == ST_CAPTURE) && last_vec;
   assign scan_enable = state == ST_SHIFT;
   assign done        = state == ST_DONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shift_cnt <= '0;
         vec_cnt   <= '0;
         seed_cnt  <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  shift_cnt <= '0;
                  vec_cnt   <= '0;
                  seed_cnt  <= '0;
                  state     <= (test_length == '0) ? ST_DONE : ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (last_shift) begin
                     shift_cnt <= '0;
                     state     <= ST_CAPTURE;
                  end else begin
                     shift_cnt <= shift_cnt + SH_W'(1);
                  end
               end
            end
            ST_CAPTURE: begin
               if (last_vec) begin
                  vec_cnt <= '0;
                  if (last_seed) begin
                     state <= ST_DONE;
                  end else begin
                     seed_cnt <= seed_cnt + LEN_W'(1);
                     state    <= ST_SHIFT;
                  end
               end else begin
                  vec_cnt <= vec_cnt + VEC_W'(1);
                  state   <= ST_SHIFT;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6: capture lasts a single cycle
   a_r6_capture_single: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPTURE) |=> (state != ST_CAPTURE));
   // R9: done holds until start
   a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
endmodule

// File: rtl/msic_pattern_gen.sv
module msic_pattern_gen #(
   parameter int               NUM_PI     = 8,
   parameter int               NUM_CHAINS = 4,
   parameter int               CHAIN_LEN  = 4,
   parameter int               LEN_W      = 16,
   parameter logic [NUM_PI-1:0] SEED_TAPS = 8'hB8,
   parameter logic [NUM_PI-1:0] SEED_INIT = 8'h01
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  start,
   input  logic                  seed_load,
   input  logic [NUM_PI-1:0]     seed_value,
   input  logic [LEN_W-1:0]      test_length,
   output logic [NUM_CHAINS-1:0] scan_in,
   output logic [NUM_PI-1:0]     pi_out,
   output logic                  scan_enable,
   output logic                  done
);
   if (NUM_CHAINS < 1 || NUM_CHAINS > CHAIN_LEN || NUM_CHAINS > NUM_PI) begin : g_bad_cfg
      $error("chain count must be 1..min(CHAIN_LEN, NUM_PI)");
   end
   if (LEN_W < 1) begin : g_bad_len_w
      $error("test length width must be positive");
   end

   logic                 quiet, clear_j, rotate, advance_j, step_seed;
   logic [CHAIN_LEN-1:0] jword;
   logic [NUM_PI-1:0]    seed;

   msic_sequencer #(.CHAIN_LEN(CHAIN_LEN), .LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .test_length(test_length), .quiet(quiet), .clear_j(clear_j),
      .rotate(rotate), .advance_j(advance_j), .step_seed(step_seed),
      .scan_enable(scan_enable), .done(done)
   );

   msic_seed_lfsr #(.WIDTH(NUM_PI), .TAPS(SEED_TAPS), .INIT(SEED_INIT)) u_seed (
      .clk(clk), .rst_n(rst_n), .load_en(seed_load && quiet),
      .load_val(seed_value), .step_en(step_seed), .seed(seed)
   );

   msic_johnson #(.LEN(CHAIN_LEN)) u_john (
      .clk(clk), .rst_n(rst_n), .clear(clear_j), .rotate(rotate),
      .advance(advance_j), .word(jword)
   );

   for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain_xor
      assign scan_in[g] = jword[g] ^ seed[g];
   end

   assign pi_out = seed;
endmodule

// File: tb/test_msic_pattern_gen.sv
module test_msic_pattern_gen;
   localparam int L = 4;
   localparam int M = 4;

   logic        clk = 0, rst_n = 0, tick = 1, start = 0, seed_load = 0;
   logic [7:0]  seed_value = '0;
   logic [15:0] test_length = '0;
   logic [3:0]  scan_in;
   logic [7:0]  pi_out;
   logic        scan_enable, done;
   int          n_chk = 0, n_fail = 0, wd = 0;

   always #4 clk = ~clk;

   msic_pattern_gen i_msic_pattern_gen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .seed_load(seed_load), .seed_value(seed_value),
      .test_length(test_length), .scan_in(scan_in), .pi_out(pi_out),
      .scan_enable(scan_enable), .done(done)
   );

   localparam logic [7:0]  T_SEED [4] = '{8'h01, 8'hA5, 8'h3C, 8'hFF};
   localparam logic [15:0] T_LEN  [4] = '{16'd1, 16'd2, 16'd1, 16'd3};
   localparam logic        T_ALT  [4] = '{1'b0, 1'b0, 1'b1, 1'b0};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] lfsr_next(input logic [7:0] s);
      return {1'b0, s[7:1]} ^ (s[0] ? 8'hB8 : 8'h00);
   endfunction

   function automatic logic jbit(input int v, input int b);
      return (v <= L) ? (b < v) : (b >= v - L);
   endfunction

   function automatic logic [3:0] exp_word(input int v, input int k, input logic [7:0] s);
      logic [3:0] e;
      for (int i = 0; i < M; i++) e[i] = jbit(v, ((i - k) % L + L) % L) ^ s[i];
      return e;
   endfunction

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", wd);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic load_seed(input logic [7:0] val);
      @(negedge clk); seed_load = 1; seed_value = val;
      @(negedge clk); seed_load = 0;
   endtask

   task automatic run_entry(input logic [7:0] sd, input logic [15:0] len, input logic alt);
      int v = 0, k = 0, got = 0, gap = 0, gap_bad = 0;
      bit gap_on = 0;
      logic [7:0] s = sd;
      load_seed(sd);
      test_length = len; start = 1;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk); start = 0;
         tick = (alt && (cyc % 2 == 1)) ? 1'b0 : 1'b1;
         #1;
         if (done) break;
         if (cyc == 0) chk("R9 start", {30'd0, done, scan_enable}, 32'd1);
         if (scan_enable) begin
            if (gap_on) begin
               if (gap != 1) gap_bad++;
               gap_on = 0;
            end
            if (tick) begin
               chk(alt ? "R7 shift" : "R4 shift", scan_in, exp_word(v, k, s));
               chk("R10 pi", pi_out, s);
               got++; k++;
               if (k == L) begin k = 0; v++; end
               if (v == 2 * L) begin v = 0; s = lfsr_next(s); end
            end
         end else begin
            if (!gap_on) begin gap_on = 1; gap = 0; end
            gap++;
         end
      end
      tick = 1;
      chk("R8 count", got, len * 2 * L * L);
      chk("R6 gaps", gap_bad, 0);
      chk("R5 seed", pi_out, s);
      repeat (3) @(negedge clk);
      #1 chk("R9 hold", {31'd0, done}, 32'd1);
   endtask

   initial begin
      logic [7:0] s2;
      int highs;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 se", {31'd0, scan_enable}, 0);
      chk("R1 done", {31'd0, done}, 0);
      chk("R1 pi", pi_out, 8'h01);
      chk("R1 scan", scan_in, 4'b0001);

      for (int e = 0; e < 4; e++) run_entry(T_SEED[e], T_LEN[e], T_ALT[e]);

      // R3: load attempt mid-run is ignored
      load_seed(8'h5A);
      test_length = 16'd1; start = 1;
      @(negedge clk); start = 0;
      repeat (4) @(negedge clk);
      seed_load = 1; seed_value = 8'h77;
      @(negedge clk); seed_load = 0;
      #1 chk("R3 pi", pi_out, 8'h5A);
      for (int c = 0; c < 300 && !done; c++) @(negedge clk);
      s2 = lfsr_next(8'h5A);
      #1 chk("R5 pi", pi_out, s2);

      // R2: zero seed rejected, nonzero accepted
      load_seed(8'h00);
      #1 chk("R2 zero", pi_out, s2);
      load_seed(8'hC3);
      #1 chk("R2 load", pi_out, 8'hC3);

      // R8: zero test length
      test_length = 16'd0; start = 1;
      highs = 0;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk); start = 0; #1;
         if (scan_enable) highs++;
      end
      chk("R8 zero shifts", highs, 0);
      chk("R8 zero done", {31'd0, done}, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule